// File: doc/BRIEF.md
# Video Capture Window Generator

This block cuts a rectangular region of interest out of a digitized interlaced video stream. It runs on the half-rate pixel clock (13.5 MHz, half of the 27 MHz decoder reference) and watches the decoder's line-active and field-active levels. From them it produces a gated field-valid level, a gated line-valid level, and a write strobe for an external image FIFO. The strobe is high only for pixels inside the window.

Two cascaded saturating counters build the window. A line counter advances on each new line while the field is active. A pixel counter advances on each pixel clock while the line is active. The window bounds and the counter widths are parameters. The defaults cover pixel counts 81 to 240, which is 160 pixels per line.

The block also samples the FIFO half-full flag. It raises a latched capture-done interrupt toward the host processor, and the host clears it with a one-cycle pulse. The input is PAL video, with a 64 µs line period and a 20 ms field period.

Top module: `vid_window_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are low after that edge and both counters are cleared.
- R2: The pixel count becomes 1 on the first clock edge at which `line_sync` is sampled high after being low, and rises by one on each later edge with `line_sync` high. `line_valid` is registered on that same edge, and is high exactly when the new count lies in [H_FIRST, H_LAST]. The defaults are 81 and 240, giving 160 pixels per line.
- R3: After any clock edge at which `line_sync` is sampled low, `line_valid` is low.
- R4: The line count is cleared on the edge at which `field_sync` is first sampled high. If `line_sync` also rises on that edge, the count is set to 1. On each later edge where `field_sync` is high and `line_sync` rises, the count rises by one. `field_valid` is registered on that edge and is high exactly when `field_sync` is high and the new count lies in [V_FIRST, V_LAST].
- R5: After any clock edge at which `field_sync` is sampled low, `field_valid` is low.
- R6: Both counters stop at their all-ones value instead of wrapping, so a long line or a long field cannot reopen the window.
- R7: `fifo_wr_en` is high after an edge exactly when `field_valid` and `line_valid` are both high after that edge.
- R8: A low-to-high change of the sampled `fifo_half_full` sets `capture_irq` after that edge. The interrupt then holds until `irq_clear` is sampled high. When a set and a clear meet on the same edge, the set wins.
- R9: A held-high `fifo_half_full` does not set the interrupt again after it has been cleared, and `irq_clear` has no effect when no interrupt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| line_sync | input | 1 | Line-active level from the decoder |
| field_sync | input | 1 | Field-active level from the decoder |
| fifo_half_full | input | 1 | Half-full flag of the image FIFO |
| irq_clear | input | 1 | One-cycle interrupt acknowledge from the host |
| field_valid | output | 1 | Gated field level, high on window lines |
| line_valid | output | 1 | Gated line level, high on window pixels |
| fifo_wr_en | output | 1 | Image FIFO write enable |
| capture_irq | output | 1 | Latched capture-done interrupt |

## Verification
The bench builds the block with a 5-bit pixel counter, a pixel window of 5 to 12, a 4-bit line counter and a line window of 3 to 5. These small values let short synthetic lines and fields reach every boundary within a few hundred cycles. A 50-cycle line and a 25-line field drive both counters past their all-ones value. If either counter wrapped, the window would reopen at pixel 37 or at lines 19 to 21, so saturation is observable at the outputs. Lines of 4 and 12 active cycles probe the edges of the horizontal window. A field-inactive line shows that the field gate blocks every write.

// File: rtl/vwin_pkg.sv
package vwin_pkg;
  // bit positions in the sampled-input vector
  localparam int IDX_LINE  = 0;
  localparam int IDX_FIELD = 1;
  localparam int IDX_HALF  = 2;
  localparam int NUM_SAMPLED = 3;

  // default window bounds (inclusive)
  localparam int DEF_H_FIRST = 81;
  localparam int DEF_H_LAST  = 240;
  localparam int DEF_V_FIRST = 21;
  localparam int DEF_V_LAST  = 60;
endpackage

// File: rtl/vwin_edge_detect.sv
module vwin_edge_detect #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/vwin_span_counter.sv
module vwin_span_counter #(
  parameter int W     = 11,
  parameter int FIRST = 81,
  parameter int LAST  = 240
) (
  input  logic clk,
  input  logic rst,
  input  logic gate,
  input  logic clear,
  input  logic step,
  output logic in_window_d,
  output logic in_window_q
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};
  localparam logic [W-1:0] LO   = FIRST[W-1:0];
  localparam logic [W-1:0] HI   = LAST[W-1:0];
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clear)
      cnt_d = step ? ONE : '0;
    else if (step && cnt_q != CMAX)
      cnt_d = cnt_q + ONE;
    else
      cnt_d = cnt_q;
  end

  assign in_window_d = gate && (cnt_d >= LO) && (cnt_d <= HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      in_window_q <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      in_window_q <= in_window_d;
    end
  end
endmodule

// File: rtl/vwin_irq_latch.sv
module vwin_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst)        irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/vid_window_gen.sv
module vid_window_gen
  import vwin_pkg::*;
#(
  parameter int H_CNT_W = 11,
  parameter int H_FIRST = DEF_H_FIRST,
  parameter int H_LAST  = DEF_H_LAST,
  parameter int V_CNT_W = 10,
  parameter int V_FIRST = DEF_V_FIRST,
  parameter int V_LAST  = DEF_V_LAST
) (
  input  logic clk,
  input  logic rst,
  input  logic line_sync,
  input  logic field_sync,
  input  logic fifo_half_full,
  input  logic irq_clear,
  output logic field_valid,
  output logic line_valid,
  output logic fifo_wr_en,
  output logic capture_irq
);
  logic [NUM_SAMPLED-1:0] sampled, rises;
  logic lv_d, fv_d;

  assign sampled[IDX_LINE]  = line_sync;
  assign sampled[IDX_FIELD] = field_sync;
  assign sampled[IDX_HALF]  = fifo_half_full;

  vwin_edge_detect #(.N(NUM_SAMPLED)) u_edges (
    .clk(clk), .rst(rst), .sig_i(sampled), .rise_o(rises)
  );

  // pixel counter: runs while the line is active
  vwin_span_counter #(.W(H_CNT_W), .FIRST(H_FIRST), .LAST(H_LAST)) u_pix (
    .clk(clk), .rst(rst),
    .gate(line_sync),
    .clear(rises[IDX_LINE]),
    .step(line_sync),
    .in_window_d(lv_d),
    .in_window_q(line_valid)
  );

  // line counter: counts new lines while the field is active
  vwin_span_counter #(.W(V_CNT_W), .FIRST(V_FIRST), .LAST(V_LAST)) u_lin (
    .clk(clk), .rst(rst),
    .gate(field_sync),
    .clear(rises[IDX_FIELD]),
    .step(field_sync && rises[IDX_LINE]),
    .in_window_d(fv_d),
    .in_window_q(field_valid)
  );

  always_ff @(posedge clk) begin
    if (rst) fifo_wr_en <= 1'b0;
    else     fifo_wr_en <= fv_d && lv_d;
  end

  vwin_irq_latch u_irq (
    .clk(clk), .rst(rst),
    .set_i(rises[IDX_HALF]),
    .clr_i(irq_clear),
    .irq_o(capture_irq)
  );
endmodule

// File: rtl/vwin_checker.sv
module vwin_checker (
  input logic clk,
  input logic rst,
  input logic line_sync,
  input logic field_sync,
  input logic fifo_half_full,
  input logic irq_clear,
  input logic field_valid,
  input logic line_valid,
  input logic fifo_wr_en,
  input logic capture_irq
);
  assert_lv_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !line_sync |=> !line_valid);

  assert_fv_gated_R5: assert property (@(posedge clk) disable iff (rst)
    !field_sync |=> !field_valid);

  assert_wr_needs_both_R7: assert property (@(posedge clk) disable iff (rst)
    fifo_wr_en |-> (field_valid && line_valid));

  assert_both_give_wr_R7: assert property (@(posedge clk) disable iff (rst)
    (field_valid && line_valid) |-> fifo_wr_en);

  assert_irq_set_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_half_full) |=> capture_irq);

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (capture_irq && !irq_clear) |=> capture_irq);

  assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_clear && !$rose(fifo_half_full)) |=> !capture_irq);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!capture_irq && !$rose(fifo_half_full)) |=> !capture_irq);
endmodule

bind vid_window_gen vwin_checker u_vwin_checker (
  .clk(clk), .rst(rst), .line_sync(line_sync), .field_sync(field_sync),
  .fifo_half_full(fifo_half_full), .irq_clear(irq_clear),
  .field_valid(field_valid), .line_valid(line_valid),
  .fifo_wr_en(fifo_wr_en), .capture_irq(capture_irq)
);

// File: tb/test_vid_window_gen.sv
`timescale 1ns/1ps
module test_vid_window_gen;
  localparam int HW = 5, HF = 5, HL = 12, VW = 4, VF = 3, VL = 5;
  localparam int HMAX = (1 << HW) - 1;
  localparam int VMAX = (1 << VW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_sync = 1'b0, field_sync = 1'b0, fifo_half_full = 1'b0, irq_clear = 1'b0;
  logic field_valid, line_valid, fifo_wr_en, capture_irq;

  always #4 clk = ~clk;

  vid_window_gen #(.H_CNT_W(HW), .H_FIRST(HF), .H_LAST(HL),
                   .V_CNT_W(VW), .V_FIRST(VF), .V_LAST(VL)) i_vid_window_gen (
    .clk(clk), .rst(rst), .line_sync(line_sync), .field_sync(field_sync),
    .fifo_half_full(fifo_half_full), .irq_clear(irq_clear),
    .field_valid(field_valid), .line_valid(line_valid),
    .fifo_wr_en(fifo_wr_en), .capture_irq(capture_irq)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference
  int m_pix = 0, m_lin = 0;
  bit m_lv = 0, m_fv = 0, m_wr = 0, m_irq = 0;
  bit was_ls = 0, was_fs = 0, was_hf = 0, seen_ls = 0, in_rst = 1;

  always @(posedge clk) begin
    in_rst = rst;
    if (rst) begin
      m_pix = 0; m_lin = 0; m_lv = 0; m_fv = 0; m_wr = 0; m_irq = 0;
      was_ls = 0; was_fs = 0; was_hf = 0; seen_ls = 0;
    end else begin
      bit new_line;
      new_line = line_sync && !was_ls;
      if (new_line) m_pix = 1;
      else if (line_sync) m_pix = (m_pix == HMAX) ? HMAX : m_pix + 1;
      if (field_sync && !was_fs) m_lin = new_line ? 1 : 0;
      else if (field_sync && new_line) m_lin = (m_lin == VMAX) ? VMAX : m_lin + 1;
      m_lv = line_sync && (m_pix >= HF) && (m_pix <= HL);
      m_fv = field_sync && (m_lin >= VF) && (m_lin <= VL);
      m_wr = m_lv && m_fv;
      if (fifo_half_full && !was_hf) m_irq = 1;
      else if (irq_clear) m_irq = 0;
      seen_ls = line_sync;
      was_ls = line_sync; was_fs = field_sync; was_hf = fifo_half_full;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison and output tallies
  int n_lv = 0, n_wr = 0, n_fv_rise = 0;
  bit prev_fv = 0;
  always @(negedge clk) begin
    if (!done) begin
      if (in_rst) begin
        chk("R1", "outputs in reset", {field_valid, line_valid, fifo_wr_en, capture_irq}, 0);
      end else begin
        chk("R2", "line_valid", line_valid, m_lv);
        chk("R4", "field_valid", field_valid, m_fv);
        chk("R7", "fifo_wr_en", fifo_wr_en, m_wr);
        chk("R8", "capture_irq", capture_irq, m_irq);
        if (!seen_ls) chk("R3", "line_valid after low line", line_valid, 0);
      end
      n_lv += line_valid;
      n_wr += fifo_wr_en;
      if (field_valid && !prev_fv) n_fv_rise++;
      prev_fv = field_valid;
    end
  end

  task automatic zero_tallies();
    n_lv = 0; n_wr = 0; n_fv_rise = 0;
  endtask

  task automatic run_line(int hi, int lo);
    line_sync = 1'b1;
    repeat (hi) @(negedge clk);
    line_sync = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic run_field(int lines, int hi, int lo);
    field_sync = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < lines; i++) run_line(hi, lo);
    field_sync = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "field_valid in reset", field_valid, 0);
    chk("R1", "capture_irq in reset", capture_irq, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // main window: 8 lines of 20 active pixels
    zero_tallies();
    run_field(8, 20, 4);
    chk("R2", "line_valid cycles over 8 lines", n_lv, 8 * (HL - HF + 1));
    chk("R4", "field_valid openings", n_fv_rise, 1);
    chk("R7", "writes in field", n_wr, (VL - VF + 1) * (HL - HF + 1));

    // long line outside a field: pixel counter must saturate
    zero_tallies();
    run_line(50, 4);
    chk("R6", "line_valid cycles in 50-cycle line", n_lv, HL - HF + 1);
    chk("R5", "writes with field inactive", n_wr, 0);
    chk("R5", "field_valid openings with field inactive", n_fv_rise, 0);

    // long field: line counter must saturate
    zero_tallies();
    run_field(25, 14, 2);
    chk("R6", "field_valid openings in 25-line field", n_fv_rise, 1);
    chk("R6", "writes in 25-line field", n_wr, (VL - VF + 1) * (HL - HF + 1));
    chk("R3", "line_valid cycles, 25 lines", n_lv, 25 * (HL - HF + 1));

    // horizontal boundaries
    zero_tallies();
    run_line(HF - 1, 3);
    run_line(HF - 1, 3);
    chk("R2", "line_valid on lines shorter than window start", n_lv, 0);
    zero_tallies();
    run_line(HL, 3);
    chk("R2", "line_valid on line ending at window end", n_lv, HL - HF + 1);

    // interrupt
    chk("R9", "irq idle", capture_irq, 0);
    fifo_half_full = 1'b1;
    @(negedge clk);
    chk("R8", "irq set on half-full rise", capture_irq, 1);
    repeat (5) @(negedge clk);
    chk("R8", "irq held", capture_irq, 1);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    chk("R8", "irq cleared", capture_irq, 0);
    repeat (3) @(negedge clk);
    chk("R9", "no re-set with half-full held", capture_irq, 0);
    fifo_half_full = 1'b0;
    repeat (2) @(negedge clk);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    chk("R9", "clear with nothing pending", capture_irq, 0);
    fifo_half_full = 1'b1;
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    chk("R8", "set wins over clear", capture_irq, 1);
    repeat (2) @(negedge clk);

    // reset mid-activity
    line_sync = 1'b1;
    field_sync = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "irq after reset", capture_irq, 0);
    chk("R1", "line_valid after reset", line_valid, 0);
    line_sync = 1'b0;
    field_sync = 1'b0;
    fifo_half_full = 1'b0;
    rst = 1'b0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule